// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block decides which interrupt request a processor core should take next, and it tracks the chain of handlers that have interrupted one another. It serves a parameterised set of configurable request lines (16 by default) and three fixed exceptions that outrank all of them. Software programs the block through a small register bus. The registers hold a per-line enable, set-pending and clear-pending controls, a per-line priority byte, a grouping field, a global block bit and a priority threshold.

The core takes an offered request by pulsing `take_ack`. The block then pushes the vector and its preemption level onto an internal stack of active handlers. The core signals a handler exit with `ret`. If another eligible request beats the level that would resume, the block hands control straight to it by replacing the top of the stack, and it flags this with `tail_chain`. Vector numbers are 0 for none, 1 to 3 for the fixed exceptions (most urgent first), and 16+i for configurable line i.

Top module: `irq_grp_arbiter`

## Requirements
- R1: A priority byte keeps only its upper PB bits (PB=4). Reading a priority at address 0x20+i returns the stored bits in [7:4] with [3:0] always zero. The threshold at address 0x06 reads back the same way.
- R2: A smaller priority value is more urgent. Among eligible requests with equal priority the lowest line number wins. `cur_pend` shows the best eligible vector, or 0 when there is none.
- R3: The grouping field at address 0x04 (reset value 4) gives the number of upper priority bits that form the preemption level, saturating at PB. The remaining bits are sub-priority. With value 0, no configurable request can preempt another.
- R4: Sub-priority only orders pending requests. A request whose preemption level equals that of the active handler is not offered.
- R5: `take_req` is high, with the winner on `take_vec`, only when the winner's preemption level is strictly more urgent than the level of the top active handler. Idle counts as least urgent.
- R6: Fixed exceptions (input bit 0, 1, 2 giving vector 1, 2, 3) outrank every configurable line and ignore both masks. Their pending flag clears when they are taken. Status at address 0x07 shows fixed active bits in [2:0] and fixed pending bits in [6:4].
- R7: With the global block bit (address 0x05, bit 0) set, no configurable line is eligible.
- R8: A nonzero threshold makes every configurable line whose priority value is greater than or equal to the threshold ineligible. A zero threshold blocks nothing.
- R9: A line is eligible only with both its enable bit (address 0x00) and its pending bit set. Taking a line does not clear its pending bit, so an uncleared line is taken again on return.
- R10: On `ret`, if the winner beats the level below the returning handler, the block replaces the top of the stack with the winner in the same cycle. It raises `tail_chain` with the vector on `take_vec`, and the nesting depth stays the same.
- R11: Address 0x03 reports one active bit per configurable line. The bit sets on take and clears on return.
- R12: Writing ones to address 0x01 or a high `irq_in` bit sets pending bits. Writing ones to address 0x02 clears them. Both addresses read the pending bits. After reset, nothing is enabled, pending or active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_in | input | NSRC | Request lines, each high cycle sets pending |
| exc_req | input | 3 | Fixed exception requests |
| take_ack | input | 1 | Core accepts the offered request |
| ret | input | 1 | Core returns from the top handler |
| take_req | output | 1 | A request is offered for preemption |
| take_vec | output | 8 | Offered or tail-chained vector, 0 otherwise |
| tail_chain | output | 1 | Return is handed over directly to a new vector |
| cur_pend | output | 8 | Best eligible vector regardless of active level |

## Verification
The hardest case to reach is a tail-chain that skips a level. The handler being left must sit above another active handler, and a pending request must be eligible against the lower level while losing to the one being left. The bench builds this by taking a mid-urgency line, preempting it with a more urgent one, then raising a third line between the two. That third line stays pending until the return. The bench also clears the pending bits of the first two lines, so that re-entry does not hide the hand-over.

// File: rtl/irq_grp_arbiter.sv
module irq_grp_arbiter #(
  parameter int NSRC = 16,
  parameter int PB   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] irq_in,
  input  logic [2:0]      exc_req,
  input  logic            take_ack,
  input  logic            ret,
  output logic            take_req,
  output logic [7:0]      take_vec,
  output logic            tail_chain,
  output logic [7:0]      cur_pend
);
  localparam int KW    = PB + 2;
  localparam int DEPTH = 3 + (1 << PB);
  localparam int SPW   = $clog2(DEPTH + 1);
  localparam logic [KW-1:0] IDLE = {KW{1'b1}};

  logic [NSRC-1:0] en_r, pend_r, act_r;
  logic [2:0]      exc_pend, exc_act;
  logic [PB-1:0]   prio_r [NSRC];
  logic [2:0]      grp_r;
  logic            gmask_r;
  logic [PB-1:0]   thr_r;
  logic [7:0]      stk_vec [DEPTH];
  logic [KW-1:0]   stk_key [DEPTH];
  logic [SPW-1:0]  sp;

  logic [NSRC-1:0] set_w, clr_w, elig;
  logic [PB-1:0]   premask;
  logic            win_valid;
  logic [7:0]      win_vec;
  logic [KW-1:0]   win_key, act_key, below_key;
  logic [7:0]      top_vec;
  logic            push, pop, swap;
  logic [NSRC-1:0] act_set, act_clr;
  logic [2:0]      fx_set, fx_clr;

  assign set_w = (bus_wr && bus_addr == 6'h01) ? bus_wdata[NSRC-1:0] : '0;
  assign clr_w = (bus_wr && bus_addr == 6'h02) ? bus_wdata[NSRC-1:0] : '0;

  always_comb begin
    int npre;
    npre = (int'(grp_r) > PB) ? PB : int'(grp_r);
    for (int b = 0; b < PB; b++) premask[b] = (b >= PB - npre);
  end

  always_comb
    for (int i = 0; i < NSRC; i++)
      elig[i] = en_r[i] && pend_r[i] && !gmask_r &&
                !((thr_r != '0) && (prio_r[i] >= thr_r));

  always_comb begin
    logic [PB-1:0] best_p;
    logic          found;
    found     = 1'b0;
    best_p    = '1;
    win_vec   = 8'd0;
    for (int i = 0; i < NSRC; i++)
      if (elig[i] && (!found || prio_r[i] < best_p)) begin
        found   = 1'b1;
        best_p  = prio_r[i];
        win_vec = 8'(16 + i);
      end
    win_valid = found;
    win_key   = found ? KW'(3) + KW'(best_p & premask) : IDLE;
    for (int j = 2; j >= 0; j--)
      if (exc_pend[j]) begin
        win_valid = 1'b1;
        win_vec   = 8'(j + 1);
        win_key   = KW'(j);
      end
  end

  assign act_key   = (sp == '0) ? IDLE : stk_key[sp - 1'b1];
  assign below_key = (sp < SPW'(2)) ? IDLE : stk_key[sp - SPW'(2)];
  assign top_vec   = (sp == '0) ? 8'd0 : stk_vec[sp - 1'b1];

  assign take_req   = win_valid && (win_key < act_key);
  assign swap       = ret && (sp != '0) && win_valid && (win_key < below_key);
  assign tail_chain = swap;
  assign push       = take_req && take_ack && !ret;
  assign pop        = ret && (sp != '0) && !swap;
  assign take_vec   = (take_req || swap) ? win_vec : 8'd0;
  assign cur_pend   = win_valid ? win_vec : 8'd0;

  always_comb begin
    act_set = '0; act_clr = '0; fx_set = '0; fx_clr = '0;
    for (int j = 0; j < 3; j++) begin
      if ((push || swap) && win_vec == 8'(j + 1)) fx_set[j] = 1'b1;
      if ((pop || swap) && top_vec == 8'(j + 1)) fx_clr[j] = 1'b1;
    end
    for (int i = 0; i < NSRC; i++) begin
      if ((push || swap) && win_vec == 8'(16 + i)) act_set[i] = 1'b1;
      if ((pop || swap) && top_vec == 8'(16 + i)) act_clr[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r     <= '0;
      pend_r   <= '0;
      act_r    <= '0;
      exc_pend <= '0;
      exc_act  <= '0;
      grp_r    <= 3'(PB);
      gmask_r  <= 1'b0;
      thr_r    <= '0;
      sp       <= '0;
      for (int i = 0; i < NSRC; i++) prio_r[i] <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        stk_vec[d] <= '0;
        stk_key[d] <= '0;
      end
    end else begin
      pend_r   <= (pend_r & ~clr_w) | set_w | irq_in;
      exc_pend <= (exc_pend & ~fx_set) | exc_req;
      act_r    <= (act_r & ~act_clr) | act_set;
      exc_act  <= (exc_act & ~fx_clr) | fx_set;
      if (bus_wr) begin
        case (bus_addr)
          6'h00: en_r    <= bus_wdata[NSRC-1:0];
          6'h04: grp_r   <= bus_wdata[2:0];
          6'h05: gmask_r <= bus_wdata[0];
          6'h06: thr_r   <= bus_wdata[7 -: PB];
          default: ;
        endcase
        for (int i = 0; i < NSRC; i++)
          if (bus_addr == 6'(32 + i)) prio_r[i] <= bus_wdata[7 -: PB];
      end
      if (push) begin
        stk_vec[sp] <= win_vec;
        stk_key[sp] <= win_key;
        sp          <= sp + 1'b1;
      end else if (swap) begin
        stk_vec[sp - 1'b1] <= win_vec;
        stk_key[sp - 1'b1] <= win_key;
      end else if (pop) begin
        sp <= sp - 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      6'h00: bus_rdata[NSRC-1:0] = en_r;
      6'h01,
      6'h02: bus_rdata[NSRC-1:0] = pend_r;
      6'h03: bus_rdata[NSRC-1:0] = act_r;
      6'h04: bus_rdata[2:0]      = grp_r;
      6'h05: bus_rdata[0]        = gmask_r;
      6'h06: bus_rdata[7 -: PB]  = thr_r;
      6'h07: bus_rdata[6:0]      = {exc_pend, 1'b0, exc_act};
      default: ;
    endcase
    for (int i = 0; i < NSRC; i++)
      if (bus_addr == 6'(32 + i)) bus_rdata[7 -: PB] = prio_r[i];
  end

  // R5: every push moves to a strictly more urgent level
  a_r5_push_deeper: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (act_key < $past(act_key)));

  // R7: with the global block set only fixed vectors are offered
  a_r7_gmask_fixed_only: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask_r && take_req) |-> (take_vec != 8'd0 && take_vec <= 8'd3));

  // R6: a taken fixed exception drops its pending flag unless re-requested
  a_r6_fixed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (push && take_vec == 8'd1) |=> (!exc_pend[0] || $past(exc_req[0])));

  // R1: low priority bits read as zero
  a_r1_prio_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= 6'h20) |-> (bus_rdata[7-PB:0] == '0));

  // R10: a hand-over keeps the nesting depth
  a_r10_tail_same_depth: assert property (@(posedge clk) disable iff (!rst_n)
    tail_chain |=> (sp == $past(sp)));

  // R11: no handler on the stack means no active status
  a_r11_idle_no_active: assert property (@(posedge clk) disable iff (!rst_n)
    (sp == '0) |-> (act_r == '0 && exc_act == '0));
endmodule

// File: tb/irq_grp_arbiter_tb.sv
module irq_grp_arbiter_tb_top;
  localparam int NSRC = 16;
  localparam logic [5:0] A_EN = 6'h00, A_SETP = 6'h01, A_CLRP = 6'h02,
    A_ACT = 6'h03, A_GRP = 6'h04, A_GM = 6'h05, A_THR = 6'h06, A_FIX = 6'h07;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NSRC-1:0] irq_in = '0;
  logic [2:0] exc_req = '0;
  logic take_ack = 1'b0, ret = 1'b0;
  logic take_req, tail_chain;
  logic [7:0] take_vec, cur_pend;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  irq_grp_arbiter #(.NSRC(NSRC), .PB(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .exc_req(exc_req), .take_ack(take_ack), .ret(ret), .take_req(take_req),
    .take_vec(take_vec), .tail_chain(tail_chain), .cur_pend(cur_pend));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; irq_in = '0; exc_req = '0; take_ack = 1'b0; ret = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic offer(input string req, input logic exp_req, input logic [7:0] exp_vec);
    #1;
    chk(req, {31'd0, take_req}, {31'd0, exp_req});
    chk(req, {24'd0, take_vec}, {24'd0, exp_vec});
  endtask

  task automatic ack();
    take_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    take_ack = 1'b0;
  endtask

  task automatic do_ret(input string req, input logic exp_tail, input logic [7:0] exp_vec);
    ret = 1'b1; #1;
    chk(req, {31'd0, tail_chain}, {31'd0, exp_tail});
    chk(req, {24'd0, take_vec}, {24'd0, exp_vec});
    @(posedge clk); @(negedge clk);
    ret = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    offer("R12 reset offer", 1'b0, 8'd0);
    chk("R12 reset cur_pend", {24'd0, cur_pend}, 32'd0);
    rd("R12 reset enable", A_EN, 32'd0);
    rd("R12 reset pending", A_SETP, 32'd0);
    rd("R3 reset grouping", A_GRP, 32'd4);
  endtask

  task automatic t_prio_rw();
    do_reset();
    wr(6'h23, 32'hAB);
    rd("R1 priority readback", 6'h23, 32'hA0);
    wr(A_THR, 32'h5F);
    rd("R1 threshold readback", A_THR, 32'h50);
  endtask

  task automatic t_enable_reenter();
    do_reset();
    wr(6'h25, 32'h80);
    wr(A_SETP, 32'h20);
    offer("R9 not enabled", 1'b0, 8'd0);
    wr(A_EN, 32'h20);
    offer("R9 enabled offer", 1'b1, 8'd21);
    ack();
    rd("R11 active bit set", A_ACT, 32'h20);
    offer("R5 same level not offered", 1'b0, 8'd0);
    do_ret("R9 re-entry via R10 hand-over", 1'b1, 8'd21);
    rd("R11 active kept after re-entry", A_ACT, 32'h20);
    wr(A_CLRP, 32'h20);
    do_ret("R10 plain return", 1'b0, 8'd0);
    rd("R11 active cleared", A_ACT, 32'h0);
  endtask

  task automatic t_order();
    do_reset();
    wr(A_EN, 32'hFFFF);
    wr(6'h22, 32'h40);
    wr(6'h27, 32'h20);
    wr(6'h29, 32'h20);
    wr(A_SETP, 32'h284);
    chk("R2 lowest value and line wins", {24'd0, cur_pend}, 32'd23);
    wr(A_CLRP, 32'h80);
    chk("R2 tie goes to next line", {24'd0, cur_pend}, 32'd25);
  endtask

  task automatic t_grouping();
    do_reset();
    wr(A_GRP, 32'd2);
    wr(A_EN, 32'hFFFF);
    wr(6'h21, 32'h90);
    wr(6'h22, 32'h80);
    wr(6'h23, 32'h70);
    wr(A_SETP, 32'h2);
    offer("R5 first take", 1'b1, 8'd17);
    ack();
    wr(A_SETP, 32'h4);
    offer("R4 sub-priority no preempt", 1'b0, 8'd0);
    chk("R4 still pending best", {24'd0, cur_pend}, 32'd18);
    wr(A_SETP, 32'h8);
    offer("R5 more urgent group preempts", 1'b1, 8'd19);
    do_reset();
    wr(A_GRP, 32'd0);
    wr(A_EN, 32'hFFFF);
    wr(6'h21, 32'hF0);
    wr(6'h22, 32'h00);
    wr(A_SETP, 32'h2);
    ack();
    wr(A_SETP, 32'h4);
    offer("R3 zero grouping no preempt", 1'b0, 8'd0);
  endtask

  task automatic t_fixed_gmask();
    do_reset();
    wr(A_EN, 32'h10);
    wr(6'h24, 32'h30);
    wr(A_SETP, 32'h10);
    wr(A_GM, 32'd1);
    offer("R7 global block", 1'b0, 8'd0);
    chk("R7 global block cur_pend", {24'd0, cur_pend}, 32'd0);
    exc_req = 3'b010;
    @(posedge clk); @(negedge clk);
    exc_req = '0;
    offer("R6 fixed ignores mask", 1'b1, 8'd2);
    ack();
    rd("R6 fixed active, pending cleared", A_FIX, 32'h02);
    exc_req = 3'b001;
    @(posedge clk); @(negedge clk);
    exc_req = '0;
    offer("R6 most urgent fixed preempts", 1'b1, 8'd1);
    wr(A_GM, 32'd0);
    chk("R6 fixed outranks configurable", {24'd0, cur_pend}, 32'd1);
  endtask

  task automatic t_threshold();
    do_reset();
    wr(A_EN, 32'hFFFF);
    wr(6'h24, 32'h50);
    wr(6'h26, 32'h40);
    wr(A_SETP, 32'h50);
    wr(A_THR, 32'h50);
    chk("R8 below threshold passes", {24'd0, cur_pend}, 32'd22);
    wr(A_CLRP, 32'h40);
    offer("R8 equal to threshold blocked", 1'b0, 8'd0);
    wr(A_THR, 32'h00);
    offer("R8 zero threshold disabled", 1'b1, 8'd20);
  endtask

  task automatic t_lines();
    do_reset();
    wr(A_EN, 32'h400);
    irq_in = 16'h0400;
    @(posedge clk); @(negedge clk);
    irq_in = '0;
    rd("R12 line sets pending", A_SETP, 32'h400);
    offer("R12 line offered", 1'b1, 8'd26);
    wr(A_CLRP, 32'h400);
    rd("R12 clear pending", A_CLRP, 32'h0);
  endtask

  task automatic t_nested_tail();
    do_reset();
    wr(A_EN, 32'hFFFF);
    wr(6'h21, 32'h80);
    wr(6'h22, 32'h40);
    wr(6'h23, 32'h60);
    wr(A_SETP, 32'h2);
    ack();
    wr(A_SETP, 32'h4);
    offer("R5 nested preempt", 1'b1, 8'd18);
    ack();
    wr(A_SETP, 32'h8);
    offer("R5 between levels held", 1'b0, 8'd0);
    wr(A_CLRP, 32'h6);
    do_ret("R10 hand-over past level", 1'b1, 8'd19);
    rd("R11 active after hand-over", A_ACT, 32'h0A);
    wr(A_CLRP, 32'h8);
    do_ret("R10 resume below", 1'b0, 8'd0);
    rd("R11 active after resume", A_ACT, 32'h02);
  endtask

  initial begin
    t_reset();
    t_prio_rw();
    t_enable_reenter();
    t_order();
    t_grouping();
    t_fixed_gmask();
    t_threshold();
    t_lines();
    t_nested_tail();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule